// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A, where P is a power-of-two prescaler modulus (8, 16, 32 or 64). It produces a one-clock feedback pulse once per N input clocks, which a phase detector compares against a divided reference. There is no full-width N counter. A dual-modulus prescaler counts either P+1 or P input clocks per prescaler cycle. A short swallow counter (A) keeps the prescaler in its P+1 mode for the first A prescaler cycles of every output period. A longer main counter (B) ends the period after B prescaler cycles in total. Only the prescaler runs at the full input rate, so it is the only counter that must fit the fast clock. The prescaler modulus is meant to be picked so that its output rate stays at or below the limit of the slower A/B counters (300 MHz in the target system).

Software loads a setting (prescaler select, A, B) into a staging register with a one-clock `cfg_load` strobe. The divider adopts a staged setting only at an output-period boundary, or at once when it is idle. A staged setting is legal when B is at least A and at least 3. A setting that breaks this rule raises `cfg_bad`. No further feedback pulses are produced until a legal setting is loaded. The pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. The feedback pulse is a timing event and cannot be stalled.

Top module: `psw_divider`

## Requirements
- R1: Reset state. During and right after reset, `fb_pulse` = 0, `mod_ctl` = 0, and `cfg_bad` = 1. The staged setting resets to A = 0 and B = 0, which is illegal.
- R2: While enabled with a legal setting, successive `fb_pulse` assertions are exactly B·P + A input clocks apart. P = 8 << `cfg_psel`, so select codes 0, 1, 2 and 3 give P = 8, 16, 32 and 64.
- R3: In each output period, `mod_ctl` is high for exactly A·(P+1) clocks, counted from the clock in which the period's pulse is visible. It is low for the rest of the period. With A = 0 it never rises. With A = B it stays high for the whole period.
- R4: `fb_pulse` is high for one clock only.
- R5: `cfg_bad` shows, from the clock after the `cfg_load` strobe, whether the staged setting breaks the rule B ≥ A and B ≥ 3.
- R6: When the staged setting is illegal at a period boundary, the running period still ends with its pulse. After that no pulse occurs and `mod_ctl` stays low until a legal setting is staged. Division then restarts with that setting.
- R7: A setting staged in the middle of a period does not change that period's length. It takes effect from the next period.
- R8: When `en` is low, the divider stops within one clock: no pulses, and `mod_ctl` low. When `en` is high again with a legal staged setting, a fresh period starts with that setting.
- R9: Large ratios divide exactly: 4500 (P=16, B=281, A=4), 5800 (P=32, B=181, A=8), 29000 (P=64, B=453, A=8), and 28575 (P=32, B=891, A=63).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low stops the divider at once |
| cfg_load | input | 1 | One-clock strobe that stages `cfg_psel`, `cfg_a`, `cfg_b` |
| cfg_psel | input | 2 | Prescaler select, P = 8 << value |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| fb_pulse | output | 1 | One-clock feedback pulse, once per N clocks |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |
| cfg_bad | output | 1 | Staged setting is illegal |

## Verification
The assertions assume that `en` and the setting pins are stable and sampled at clock edges, and that only legal settings ever reach the counters. Under that assumption, B is never below A during a period, and every period is long enough (at least 24 clocks) that two pulses can never be adjacent. The stimulus changes inputs only on the falling clock edge. It stages illegal settings only while checking the suppression behaviour, and it raises `en` one clock after a strobe so the divider starts from the new setting. Random settings draw B from 3 to 30 and A from 0 to B, which keeps every random case legal.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } psw_state_e;
endpackage

// File: rtl/psw_cfg_stage.sv
module psw_cfg_stage #(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int SEL_W = 2,
  parameter int B_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  output logic [SEL_W-1:0] stg_sel,
  output logic [A_W-1:0]   stg_a,
  output logic [B_W-1:0]   stg_b,
  output logic             stg_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_sel <= '0;
      stg_a   <= '0;
      stg_b   <= '0;
    end else if (load) begin
      stg_sel <= sel_in;
      stg_a   <= a_in;
      stg_b   <= b_in;
    end
  end

  // legal when the main count covers the swallow count and a minimum length
  always_comb begin
    stg_ok = (stg_b >= B_W'(B_MIN)) && (stg_b >= B_W'(stg_a));
  end
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int SEL_W     = 2,
  parameter int PMIN_LOG2 = 3,
  parameter int PC_W      = PMIN_LOG2 + (1 << SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic             reload,
  input  logic [SEL_W-1:0] len_sel,
  input  logic             len_plus1,
  output logic             tick,
  output logic [PC_W-1:0]  pc_o
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] len_m1;

  // prescaler cycle length minus one: P-1 or P
  always_comb begin
    base   = PC_W'(1) << PMIN_LOG2;
    base   = base << len_sel;
    len_m1 = len_plus1 ? base : base - PC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (clr) begin
      pc <= '0;
    end else if (reload) begin
      pc <= len_m1;
    end else if (active && (pc != '0)) begin
      pc <= pc - PC_W'(1);
    end
  end

  assign tick = active && (pc == '0);
  assign pc_o = pc;
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           load,
  input  logic           step,
  input  logic [A_W-1:0] a_ld,
  input  logic [B_W-1:0] b_ld,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt,
  output logic           last,
  output logic           plus1_next,
  output logic           swallow_on
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (clr) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (load) begin
      a_cnt <= a_ld;
      b_cnt <= b_ld;
    end else if (step) begin
      a_cnt <= a_cnt - A_W'(a_cnt != '0);
      b_cnt <= b_cnt - B_W'(1);
    end
  end

  assign last       = (b_cnt == B_W'(1));
  assign plus1_next = (a_cnt > A_W'(1));
  assign swallow_on = (a_cnt != '0);
endmodule

// File: rtl/psw_divider.sv
module psw_divider #(
  parameter int A_W       = 6,
  parameter int B_W       = 13,
  parameter int SEL_W     = 2,
  parameter int PMIN_LOG2 = 3,
  parameter int B_MIN     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_load,
  input  logic [SEL_W-1:0] cfg_psel,
  input  logic [A_W-1:0]   cfg_a,
  input  logic [B_W-1:0]   cfg_b,
  output logic             fb_pulse,
  output logic             mod_ctl,
  output logic             cfg_bad
);
  import psw_pkg::*;

  localparam int PC_W = PMIN_LOG2 + (1 << SEL_W);

  psw_state_e       state;
  logic             running;
  logic [SEL_W-1:0] stg_sel;
  logic [A_W-1:0]   stg_a;
  logic [B_W-1:0]   stg_b;
  logic             stg_ok;
  logic [SEL_W-1:0] act_sel;
  logic             tick;
  logic             last;
  logic             plus1_next;
  logic             swallow_on;
  logic [A_W-1:0]   a_cnt;
  logic [B_W-1:0]   b_cnt;
  logic [PC_W-1:0]  pc;
  logic             boundary;
  logic             start;
  logic             restart;
  logic             ld;
  logic             step;
  logic             clr;
  logic             pulse_q;
  logic [SEL_W-1:0] len_sel;
  logic             len_plus1;

  psw_cfg_stage #(
    .A_W(A_W), .B_W(B_W), .SEL_W(SEL_W), .B_MIN(B_MIN)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .sel_in(cfg_psel), .a_in(cfg_a), .b_in(cfg_b),
    .stg_sel(stg_sel), .stg_a(stg_a), .stg_b(stg_b), .stg_ok(stg_ok)
  );

  assign running  = (state == ST_RUN);
  assign boundary = tick && last;
  assign start    = (state == ST_IDLE) && en && stg_ok;
  assign restart  = running && en && boundary && stg_ok;
  assign ld       = start || restart;
  assign step     = running && en && tick && !last;
  assign clr      = running && (!en || (boundary && !stg_ok));

  // a new period takes its modulus from the staged setting
  assign len_sel   = ld ? stg_sel : act_sel;
  assign len_plus1 = ld ? (stg_a != '0) : plus1_next;

  psw_prescaler #(
    .SEL_W(SEL_W), .PMIN_LOG2(PMIN_LOG2), .PC_W(PC_W)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .active(running && en),
    .reload(ld || step), .len_sel(len_sel), .len_plus1(len_plus1),
    .tick(tick), .pc_o(pc)
  );

  psw_swallow #(
    .A_W(A_W), .B_W(B_W)
  ) u_swallow (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(ld), .step(step),
    .a_ld(stg_a), .b_ld(stg_b),
    .a_cnt(a_cnt), .b_cnt(b_cnt), .last(last),
    .plus1_next(plus1_next), .swallow_on(swallow_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      act_sel <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= running && en && boundary;
      if (ld) begin
        act_sel <= stg_sel;
      end
      case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN:  if (clr)   state <= ST_IDLE;
        default:            state <= ST_IDLE;
      endcase
    end
  end

  assign fb_pulse = pulse_q;
  assign mod_ctl  = swallow_on;
  assign cfg_bad  = !stg_ok;
endmodule

// File: rtl/psw_div_checker.sv
module psw_div_checker #(
  parameter int A_W       = 6,
  parameter int B_W       = 13,
  parameter int SEL_W     = 2,
  parameter int PMIN_LOG2 = 3,
  parameter int PC_W      = PMIN_LOG2 + (1 << SEL_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             fb_pulse,
  input logic             mod_ctl,
  input logic             running,
  input logic             tick,
  input logic             last,
  input logic [A_W-1:0]   a_cnt,
  input logic [B_W-1:0]   b_cnt,
  input logic [SEL_W-1:0] act_sel,
  input logic [PC_W-1:0]  pc
);
  logic [PC_W-1:0] pc_lim;
  always_comb begin
    pc_lim = PC_W'(1) << PMIN_LOG2;
    pc_lim = pc_lim << act_sel;
  end

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(running)) |-> !fb_pulse);

  a_r3_mod_falls_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctl) |-> $past(tick || !en));

  a_r3_mod_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mod_ctl);

  a_r2_b_covers_a: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (b_cnt >= B_W'(a_cnt)));

  a_r2_pc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pc <= pc_lim));

  a_r7_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(tick && last)) |-> $stable(act_sel));

  a_r8_stop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running);
endmodule

bind psw_divider psw_div_checker #(
  .A_W(A_W), .B_W(B_W), .SEL_W(SEL_W), .PMIN_LOG2(PMIN_LOG2), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fb_pulse(fb_pulse), .mod_ctl(mod_ctl),
  .running(running), .tick(tick), .last(last), .a_cnt(a_cnt), .b_cnt(b_cnt),
  .act_sel(act_sel), .pc(pc)
);

// File: tb/psw_divider_tb_top.sv
module psw_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  psel = '0;
  logic [5:0]  a_in = '0;
  logic [12:0] b_in = '0;
  logic        fb_pulse;
  logic        mod_ctl;
  logic        cfg_bad;

  always #4 clk = ~clk;

  psw_divider dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_load(cfg_load),
    .cfg_psel(psel), .cfg_a(a_in), .cfg_b(b_in),
    .fb_pulse(fb_pulse), .mod_ctl(mod_ctl), .cfg_bad(cfg_bad)
  );

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_n[$];
  int    exp_hi[$];
  string exp_req[$];
  bit    mon_skip = 1'b0;
  bit    have_last = 1'b0;
  int    last_cyc = 0;
  int    hi_cnt = 0;
  bit    started = 1'b0;
  int    cur_n = 0;
  int    cur_hi = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor: measures each period and its P+1 span
  always @(negedge clk) begin
    int    en_v;
    int    eh_v;
    string rq_v;
    if (rst_n) begin
      if (fb_pulse) begin
        if (have_last && !mon_skip) begin
          if (exp_n.size() == 0) begin
            check(1'b0, "R6", "unexpected pulse period", cyc - last_cyc, 0);
          end else begin
            en_v = exp_n.pop_front();
            eh_v = exp_hi.pop_front();
            rq_v = exp_req.pop_front();
            check((cyc - last_cyc) == en_v, rq_v, "period length", cyc - last_cyc, en_v);
            check(hi_cnt == eh_v, "R3", "mod_ctl high clocks", hi_cnt, eh_v);
          end
        end
        mon_skip  = 1'b0;
        have_last = 1'b1;
        last_cyc  = cyc;
        hi_cnt    = 0;
      end
      if (mod_ctl) hi_cnt++;
    end
  end

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic load(input int sel, input int av, input int bv);
    psel     = 2'(sel);
    a_in     = 6'(av);
    b_in     = 13'(bv);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // driver: stages a setting and pushes the periods it expects
  task automatic run_cfg(input int sel, input int av, input int bv,
                         input int k, input string req);
    int p;
    int n;
    int hi;
    p  = 8 << sel;
    n  = bv * p + av;
    hi = av * (p + 1);
    if (started) begin
      exp_n.push_back(cur_n);
      exp_hi.push_back(cur_hi);
      exp_req.push_back("R7");
      load(sel, av, bv);
    end else begin
      mon_skip = 1'b1;
      load(sel, av, bv);
      check(cfg_bad == 1'b0, "R5", "cfg_bad on legal setting", int'(cfg_bad), 0);
      en = 1'b1;
    end
    for (int i = 0; i < k; i++) begin
      exp_n.push_back(n);
      exp_hi.push_back(hi);
      exp_req.push_back(req);
    end
    repeat (k + 1) wait_pulse();
    started = 1'b1;
    cur_n   = n;
    cur_hi  = hi;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 190000);
    finish_run();
  end

  initial begin
    int cnt_p;
    int cnt_m;
    int sel;
    int bv;
    int av;
    repeat (3) @(negedge clk);
    check(fb_pulse == 1'b0, "R1", "fb_pulse in reset", int'(fb_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fb_pulse == 1'b0, "R1", "fb_pulse after reset", int'(fb_pulse), 0);
    check(mod_ctl == 1'b0, "R1", "mod_ctl after reset", int'(mod_ctl), 0);
    check(cfg_bad == 1'b1, "R1", "cfg_bad after reset", int'(cfg_bad), 1);

    run_cfg(0, 5, 20, 3, "R2");
    run_cfg(1, 3, 10, 2, "R2");
    run_cfg(3, 0, 3, 2, "R2");
    run_cfg(0, 7, 7, 2, "R3");

    // R6: illegal setting (A > B) staged mid-period
    exp_n.push_back(cur_n);
    exp_hi.push_back(cur_hi);
    exp_req.push_back("R6");
    load(0, 10, 5);
    check(cfg_bad == 1'b1, "R5", "cfg_bad with A above B", int'(cfg_bad), 1);
    wait_pulse();
    cnt_p = 0;
    cnt_m = 0;
    repeat (3 * cur_n) begin
      @(negedge clk);
      if (fb_pulse) cnt_p++;
      if (mod_ctl) cnt_m++;
    end
    check(cnt_p == 0, "R6", "pulses while illegal", cnt_p, 0);
    check(cnt_m == 0, "R6", "mod_ctl high clocks while illegal", cnt_m, 0);
    load(0, 0, 2);
    check(cfg_bad == 1'b1, "R5", "cfg_bad with B below 3", int'(cfg_bad), 1);
    started = 1'b0;
    run_cfg(0, 0, 3, 3, "R6");

    // R8: disable stops the divider, enable restarts it
    en = 1'b0;
    started = 1'b0;
    cnt_p = 0;
    cnt_m = 0;
    repeat (300) begin
      @(negedge clk);
      if (fb_pulse) cnt_p++;
      if (mod_ctl) cnt_m++;
    end
    check(cnt_p == 0, "R8", "pulses while disabled", cnt_p, 0);
    check(cnt_m == 0, "R8", "mod_ctl high clocks while disabled", cnt_m, 0);
    run_cfg(2, 9, 12, 2, "R8");

    for (int r = 0; r < 3; r++) begin
      sel = int'($urandom_range(0, 3));
      bv  = int'($urandom_range(3, 30));
      av  = int'($urandom_range(0, bv));
      run_cfg(sel, av, bv, 2, "R2");
    end

    run_cfg(1, 4, 281, 1, "R9");
    run_cfg(2, 8, 181, 1, "R9");
    run_cfg(3, 8, 453, 1, "R9");
    run_cfg(2, 63, 891, 1, "R9");
    en = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_n.size() == 0, "R2", "expected periods left unmatched", exp_n.size(), 0);
    finish_run();
  end
endmodule